// File: doc/BRIEF.md
# Merging Store Buffer

This block sits between a write-through first-level data cache and the second-level cache. Every store the processor makes arrives as one word: a block address, the word index inside the block, the word data and a byte mask. The buffer keeps up to four block-sized entries. A store to a block that already has an entry merges its bytes into that entry, so bursts of stores to one block leave as a single write. The processor waits only when all entries are full and the store cannot merge.

Entries leave in arrival order. The oldest entry is shown on the L2 write port, and the port holds it for a fixed number of cycles before the next entry takes its place. The entry being written is locked: a store that matches only that entry opens a new entry. A read miss raises a request. The buffer then refuses stores and drains every entry. One cycle after it becomes empty it gives a single grant pulse, so a read can never overtake an older store to the same data.

Top module: `store_coalesce_buf`

## Requirements
- R1: After reset the buffer is empty: `st_ready` is 1, `l2_wr_valid` is 0 and `rd_grant` is 0.
- R2: A store whose block address matches no unlocked entry allocates a new entry at the tail. The buffer holds at most four entries.
- R3: A store whose block address matches an unlocked entry merges into that entry. Newly written bytes replace older bytes, and the entry's byte mask becomes the union of the two masks.
- R4: A store that matches only the entry now being written to L2 allocates a new entry and does not change the entry on the port.
- R5: `st_ready` is 0 when all four entries are valid and the store cannot merge. It becomes 1 in the cycle after the oldest entry leaves. A merging store is accepted even when the buffer is full.
- R6: While the buffer is not empty, `l2_wr_valid` is 1 and the port shows the oldest entry unchanged for exactly 15 cycles. The next entry follows in the very next cycle, in arrival order.
- R7: Byte b (0..7) of a store to word index w lands at block byte 8*w+b, in data bits [8*(8*w+b)+7 : 8*(8*w+b)]. Its mask bit is `l2_wr_mask[8*w+b]`. Bytes that were never written read as zero.
- R8: While `rd_req` is 1, `st_ready` is 0. `rd_grant` pulses in the cycle after the first cycle in which `rd_req` is 1 and the buffer is empty.
- R9: `rd_grant` pulses only once for each request. Further pulses need `rd_req` to drop to 0 and rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted this cycle when high |
| st_blk_addr | input | 27 | Block address of the store |
| st_word | input | 2 | Word index inside the block |
| st_data | input | 64 | Store word data |
| st_mask | input | 8 | Byte enables of the store word |
| rd_req | input | 1 | Read-miss request, held until granted |
| rd_grant | output | 1 | One-cycle permission for the read |
| l2_wr_valid | output | 1 | Oldest entry is being written to L2 |
| l2_wr_addr | output | 27 | Block address of that entry |
| l2_wr_data | output | 256 | Block data of that entry |
| l2_wr_mask | output | 32 | Byte mask of that entry |

## Verification
The hardest cases to reach from the ports come from how the lock moves. In one, a store merges into the second entry in the same cycle that the oldest entry retires, and that second entry then appears on the port at once, with the merged bytes. In the other, a store matches only the locked entry and must create a duplicate entry. To reach both, the directed phase fills the buffer with a repeated head address. The random phase then sends stores over a set of only five block addresses, with several stores per drain window, so merges land on every entry position, including the retirement cycle. A behavioural queue model, compared on every cycle, catches any wrong merge target or any byte placed in the wrong lane.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

   // True when v is a positive power of two.
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/wbm_match.sv
// Address compare across all entries; the locked (head) entry never matches.
module wbm_match #(
   parameter int ENTRIES = 4,
   parameter int BADDR_W = 27,
   localparam int PTR_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] ent_v,
   input  logic [BADDR_W-1:0] ent_addr [ENTRIES],
   input  logic [PTR_W-1:0]   head,
   input  logic [BADDR_W-1:0] probe,
   output logic [ENTRIES-1:0] hit_vec
);

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign hit_vec[i] = ent_v[i] && (ent_addr[i] == probe) && (head != PTR_W'(i));
   end

endmodule

// File: rtl/wbm_drain.sv
// Fixed-latency drain timer: retires the head entry on the last cycle.
module wbm_drain #(
   parameter int DRAIN_CYCLES = 15,
   localparam int CW          = $clog2(DRAIN_CYCLES)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic pop
);

   logic [CW-1:0] cnt;

   assign pop = active && (cnt == CW'(DRAIN_CYCLES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= '0;
      else if (!active) cnt <= '0;
      else if (pop)     cnt <= '0;
      else              cnt <= cnt + CW'(1);
   end

endmodule

// File: rtl/wbm_lane.sv
// Places a store word into its lanes of a block-wide data and mask vector.
module wbm_lane #(
   parameter int BLOCK_BYTES = 32,
   parameter int WORD_BYTES  = 8,
   localparam int WORDS      = BLOCK_BYTES / WORD_BYTES,
   localparam int WIDX_W     = $clog2(WORDS)
) (
   input  logic [WIDX_W-1:0]         word,
   input  logic [WORD_BYTES*8-1:0]   wdata,
   input  logic [WORD_BYTES-1:0]     wmask,
   output logic [BLOCK_BYTES*8-1:0]  blk_data,
   output logic [BLOCK_BYTES-1:0]    blk_mask
);

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic sel;
      assign sel = (word == WIDX_W'(w));
      assign blk_mask[w*WORD_BYTES +: WORD_BYTES] = sel ? wmask : '0;
      for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
         assign blk_data[(w*WORD_BYTES+b)*8 +: 8] =
            (sel && wmask[b]) ? wdata[b*8 +: 8] : 8'h00;
      end
   end

endmodule

// File: rtl/store_coalesce_buf.sv
module store_coalesce_buf #(
   parameter int ENTRIES      = 4,
   parameter int BLOCK_BYTES  = 32,
   parameter int WORD_BYTES   = 8,
   parameter int BADDR_W      = 27,
   parameter int DRAIN_CYCLES = 15,
   localparam int WORDS       = BLOCK_BYTES / WORD_BYTES,
   localparam int WIDX_W      = $clog2(WORDS),
   localparam int BLK_W       = BLOCK_BYTES * 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    st_valid,
   output logic                    st_ready,
   input  logic [BADDR_W-1:0]      st_blk_addr,
   input  logic [WIDX_W-1:0]       st_word,
   input  logic [WORD_BYTES*8-1:0] st_data,
   input  logic [WORD_BYTES-1:0]   st_mask,
   input  logic                    rd_req,
   output logic                    rd_grant,
   output logic                    l2_wr_valid,
   output logic [BADDR_W-1:0]      l2_wr_addr,
   output logic [BLK_W-1:0]        l2_wr_data,
   output logic [BLOCK_BYTES-1:0]  l2_wr_mask
);

   localparam int PTR_W = $clog2(ENTRIES);
   localparam int CNT_W = $clog2(ENTRIES + 1);

   // elaboration-time parameter checks
   if (!wbm_pkg::is_pow2(ENTRIES) || ENTRIES < 2) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (!wbm_pkg::is_pow2(WORD_BYTES) || (BLOCK_BYTES % WORD_BYTES) != 0 || WORDS < 2) begin : g_bad_geom
      $error("BLOCK_BYTES must hold at least two power-of-two words");
   end
   if (DRAIN_CYCLES < 2) begin : g_bad_drain
      $error("DRAIN_CYCLES must be at least 2");
   end

   logic [ENTRIES-1:0]     ent_v;
   logic [BADDR_W-1:0]     ent_addr [ENTRIES];
   logic [BLK_W-1:0]       ent_data [ENTRIES];
   logic [BLOCK_BYTES-1:0] ent_mask [ENTRIES];
   logic [PTR_W-1:0]       head, tail;
   logic [CNT_W-1:0]       count;
   logic                   rd_used;

   logic [ENTRIES-1:0]     hit_vec;
   logic                   hit, st_fire, do_merge, do_alloc, drain_pop, nonempty;
   logic [BLK_W-1:0]       blk_data;
   logic [BLOCK_BYTES-1:0] blk_mask;

   wbm_match #(.ENTRIES(ENTRIES), .BADDR_W(BADDR_W)) u_match (
      .ent_v(ent_v), .ent_addr(ent_addr), .head(head),
      .probe(st_blk_addr), .hit_vec(hit_vec)
   );

   wbm_lane #(.BLOCK_BYTES(BLOCK_BYTES), .WORD_BYTES(WORD_BYTES)) u_lane (
      .word(st_word), .wdata(st_data), .wmask(st_mask),
      .blk_data(blk_data), .blk_mask(blk_mask)
   );

   assign nonempty = (count != '0);

   wbm_drain #(.DRAIN_CYCLES(DRAIN_CYCLES)) u_drain (
      .clk(clk), .rst_n(rst_n), .active(nonempty), .pop(drain_pop)
   );

   assign hit      = |hit_vec;
   assign st_ready = !rd_req && (hit || (count < CNT_W'(ENTRIES)));
   assign st_fire  = st_valid && st_ready;
   assign do_merge = st_fire && hit;
   assign do_alloc = st_fire && !hit;

   assign l2_wr_valid = nonempty;
   assign l2_wr_addr  = ent_addr[head];
   assign l2_wr_data  = ent_data[head];
   assign l2_wr_mask  = ent_mask[head];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_v    <= '0;
         head     <= '0;
         tail     <= '0;
         count    <= '0;
         rd_grant <= 1'b0;
         rd_used  <= 1'b0;
         for (int i = 0; i < ENTRIES; i++) begin
            ent_addr[i] <= '0;
            ent_data[i] <= '0;
            ent_mask[i] <= '0;
         end
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (do_merge && hit_vec[i]) begin
               for (int j = 0; j < BLOCK_BYTES; j++) begin
                  if (blk_mask[j]) ent_data[i][8*j +: 8] <= blk_data[8*j +: 8];
               end
               ent_mask[i] <= ent_mask[i] | blk_mask;
            end
         end
         if (do_alloc) begin
            ent_v[tail]    <= 1'b1;
            ent_addr[tail] <= st_blk_addr;
            ent_data[tail] <= blk_data;
            ent_mask[tail] <= blk_mask;
            tail           <= tail + PTR_W'(1);
         end
         if (drain_pop) begin
            ent_v[head] <= 1'b0;
            head        <= head + PTR_W'(1);
         end
         count    <= count + CNT_W'(do_alloc) - CNT_W'(drain_pop);
         rd_grant <= rd_req && !nonempty && !rd_used;
         rd_used  <= rd_req && (rd_used || !nonempty);
      end
   end

endmodule

// File: rtl/wbm_checker.sv
module wbm_checker #(
   parameter int ENTRIES     = 4,
   parameter int BADDR_W     = 27,
   parameter int BLOCK_BYTES = 32,
   localparam int CNT_W      = $clog2(ENTRIES + 1)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   st_ready,
   input logic                   rd_req,
   input logic                   rd_grant,
   input logic                   l2_wr_valid,
   input logic [BADDR_W-1:0]     l2_wr_addr,
   input logic [BLOCK_BYTES*8-1:0] l2_wr_data,
   input logic [CNT_W-1:0]       count,
   input logic [ENTRIES-1:0]     hit_vec,
   input logic                   drain_pop
);

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(ENTRIES));

   assert_single_merge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hit_vec) <= 1);

   assert_full_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(ENTRIES) && hit_vec == '0) |-> !st_ready);

   assert_head_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (l2_wr_valid && !drain_pop) |=> (l2_wr_valid && $stable(l2_wr_addr) && $stable(l2_wr_data)));

   assert_pop_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      drain_pop |-> l2_wr_valid);

   assert_read_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> !st_ready);

   assert_grant_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_grant |-> !l2_wr_valid);

   assert_grant_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_grant |=> !rd_grant);

endmodule

bind store_coalesce_buf wbm_checker #(
   .ENTRIES(ENTRIES), .BADDR_W(BADDR_W), .BLOCK_BYTES(BLOCK_BYTES)
) u_wbm_chk (
   .clk(clk), .rst_n(rst_n), .st_ready(st_ready), .rd_req(rd_req),
   .rd_grant(rd_grant), .l2_wr_valid(l2_wr_valid), .l2_wr_addr(l2_wr_addr),
   .l2_wr_data(l2_wr_data), .count(count), .hit_vec(hit_vec), .drain_pop(drain_pop)
);

// File: tb/store_coalesce_buf_tb.sv
module store_coalesce_buf_tb;

   localparam int DRAIN = 15;
   localparam int NENT  = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         st_valid = 1'b0;
   logic         st_ready;
   logic [26:0]  st_blk_addr = '0;
   logic [1:0]   st_word = '0;
   logic [63:0]  st_data = '0;
   logic [7:0]   st_mask = '0;
   logic         rd_req = 1'b0;
   logic         rd_grant;
   logic         l2_wr_valid;
   logic [26:0]  l2_wr_addr;
   logic [255:0] l2_wr_data;
   logic [31:0]  l2_wr_mask;

   int n_checks = 0;
   int n_fails  = 0;

   always #10 clk = ~clk;   // 50 MHz

   store_coalesce_buf u_dut (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
      .st_blk_addr(st_blk_addr), .st_word(st_word), .st_data(st_data),
      .st_mask(st_mask), .rd_req(rd_req), .rd_grant(rd_grant),
      .l2_wr_valid(l2_wr_valid), .l2_wr_addr(l2_wr_addr),
      .l2_wr_data(l2_wr_data), .l2_wr_mask(l2_wr_mask)
   );

   task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   typedef struct {
      logic [26:0]  a;
      logic [255:0] d;
      logic [31:0]  m;
   } ent_t;

   ent_t q[$];
   int   dcnt = 0;
   bit   m_grant = 0;
   bit   m_used = 0;

   function automatic int find_hit();
      for (int k = 1; k < q.size(); k++) if (q[k].a == st_blk_addr) return k;
      return -1;
   endfunction

   function automatic bit exp_ready();
      return !rd_req && (find_hit() >= 0 || q.size() < NENT);
   endfunction

   always @(posedge clk) begin : mdl
      int   hk, sz;
      bit   fire, pop;
      ent_t ne;
      if (!rst_n) begin
         q.delete(); dcnt = 0; m_grant = 0; m_used = 0;
      end else begin
         sz   = q.size();
         hk   = find_hit();
         fire = st_valid && exp_ready();
         pop  = (sz > 0) && (dcnt == DRAIN - 1);
         m_grant = rd_req && sz == 0 && !m_used;
         m_used  = rd_req && (m_used || sz == 0);
         if (fire) begin
            if (hk >= 0) ne = q[hk];
            else begin ne.a = st_blk_addr; ne.d = '0; ne.m = '0; end
            for (int b = 0; b < 8; b++) begin
               if (st_mask[b]) begin
                  ne.d[8*(8*st_word+b) +: 8] = st_data[8*b +: 8];
                  ne.m[8*st_word+b] = 1'b1;
               end
            end
            if (hk >= 0) q[hk] = ne; else q.push_back(ne);
         end
         if (sz > 0) dcnt = pop ? 0 : dcnt + 1; else dcnt = 0;
         if (pop) void'(q.pop_front());
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check(st_ready == exp_ready(), "R5/R8 st_ready", 256'(st_ready), 256'(exp_ready()));
         check(rd_grant == m_grant, "R8/R9 rd_grant", 256'(rd_grant), 256'(m_grant));
         check(l2_wr_valid == (q.size() > 0), "R6 l2_wr_valid", 256'(l2_wr_valid), 256'(q.size() > 0));
         if (q.size() > 0) begin
            check(l2_wr_addr == q[0].a, "R2/R4/R6 l2_wr_addr", 256'(l2_wr_addr), 256'(q[0].a));
            check(l2_wr_data == q[0].d, "R3/R7 l2_wr_data", l2_wr_data, q[0].d);
            check(l2_wr_mask == q[0].m, "R3/R7 l2_wr_mask", 256'(l2_wr_mask), 256'(q[0].m));
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic drive(input logic [26:0] a, input logic [1:0] w, input logic [63:0] d, input logic [7:0] m);
      st_valid = 1'b1; st_blk_addr = a; st_word = w; st_data = d; st_mask = m;
   endtask

   task automatic store(input logic [26:0] a, input logic [1:0] w, input logic [63:0] d, input logic [7:0] m);
      drive(a, w, d, m);
      @(negedge clk);
      while (!st_ready) @(negedge clk);
      @(posedge clk); #1;
      st_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_checks++; n_fails++;
      $display("FAIL watchdog act=hung exp=done");
      finish_run();
   end

   initial begin : main
      bit seen;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: empty after reset
      check(st_ready == 1'b1, "R1 st_ready", 256'(st_ready), 256'(1));
      check(l2_wr_valid == 1'b0, "R1 l2_wr_valid", 256'(l2_wr_valid), 256'(0));
      check(rd_grant == 1'b0, "R1 rd_grant", 256'(rd_grant), 256'(0));
      @(posedge clk); #1;

      // R2/R7 allocate A; R3 merges into B; R4 A again matches only locked head
      store(27'h00A, 2'd0, 64'h1111_2222_3333_4444, 8'hFF);
      store(27'h00B, 2'd3, 64'hAAAA_BBBB_CCCC_DDDD, 8'hF0);
      store(27'h00B, 2'd3, 64'h0102_0304_0506_0708, 8'h3C);
      store(27'h00B, 2'd1, 64'h5555_6666_7777_8888, 8'h81);
      store(27'h00A, 2'd2, 64'hDEAD_BEEF_0000_0001, 8'h0F);
      store(27'h00C, 2'd0, 64'h0F0F_0F0F_0F0F_0F0F, 8'h01);
      // buffer full now; R5 merge into C still accepted
      drive(27'h00C, 2'd1, 64'h7777_7777_7777_7777, 8'h02);
      @(negedge clk);
      check(st_ready == 1'b1, "R5 merge while full", 256'(st_ready), 256'(1));
      @(posedge clk); #1;
      // R2/R5 fifth distinct block must stall
      drive(27'h00D, 2'd2, 64'h9999_9999_9999_9999, 8'hFF);
      @(negedge clk);
      check(st_ready == 1'b0, "R2/R5 full stall", 256'(st_ready), 256'(0));
      while (!st_ready) @(negedge clk);
      @(posedge clk); #1 st_valid = 1'b0;

      // R8: read miss blocks stores and waits for empty; R9 single pulse
      rd_req = 1'b1;
      drive(27'h00E, 2'd0, 64'h1, 8'h01);
      @(negedge clk);
      check(st_ready == 1'b0, "R8 store blocked by read", 256'(st_ready), 256'(0));
      seen = 0;
      for (int c = 0; c < 200 && !seen; c++) begin
         if (rd_grant) begin
            seen = 1;
            check(l2_wr_valid == 1'b0, "R8 grant only when empty", 256'(l2_wr_valid), 256'(0));
         end else @(negedge clk);
      end
      check(seen, "R8 grant seen", 256'(seen), 256'(1));
      repeat (3) begin
         @(negedge clk);
         check(rd_grant == 1'b0, "R9 no second pulse", 256'(rd_grant), 256'(0));
      end
      @(posedge clk); #1;
      rd_req = 1'b0; st_valid = 1'b0;

      // random phase over a small address set (R3/R4/R6/R7 corners)
      seen = 0;
      for (int c = 0; c < 6000; c++) begin
         @(negedge clk);
         if (rd_grant) seen = 1;
         @(posedge clk); #1;
         if (rd_req && seen) begin rd_req = 1'b0; seen = 0; end
         else if (!rd_req && ($urandom_range(0, 99) < 2)) rd_req = 1'b1;
         st_valid    = ($urandom_range(0, 99) < 45);
         st_blk_addr = 27'($urandom_range(0, 4)) + 27'h100;
         st_word     = 2'($urandom_range(0, 3));
         st_data     = {$urandom, $urandom};
         st_mask     = 8'($urandom_range(1, 255));
      end
      st_valid = 1'b0; rd_req = 1'b0;
      repeat (100) @(posedge clk);
      finish_run();
   end

endmodule